// File: doc/BRIEF.md
# Halt and Wake-up Controller

This block governs a small microcontroller core's low-power halt state. A halt strobe from the core gates the system clock off, asks the watchdog to restart its count, and records in two status bits (power-down and time-out) that the core went to sleep. The controller runs on the always-on low-frequency clock, so it keeps watching for wake events while the core clock is stopped.

Four kinds of event end a halt: an external reset, a watchdog overflow, a newly raised interrupt request, and a falling edge on an input port bit that the wake mask selects. The controller ranks them, reopens the clock gate, and issues a one-cycle strobe with a one-hot resume code: continue at the next instruction, take the interrupt, warm reset (program counter and stack pointer only), or full reset. An interrupt request that was already pending when the halt began cannot wake the core. The status bits survive the wake, so software can tell why it restarted.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After power-on reset (rst_n low) sys_clk_en is 1, pdf, to_flag, wdt_clr and resume_vld are 0, and resume_act is 4'b0000.
- R2: A halt_req while running (no ext_reset) makes sys_clk_en 0, pdf 1, to_flag 0 and wdt_clr 1 on the next cycle; wdt_clr is a one-cycle pulse.
- R3: A clrwdt_req while running clears pdf and pulses wdt_clr on the next cycle, leaving to_flag unchanged; when halt_req and clrwdt_req arrive together, the halt wins.
- R4: An ext_reset in any state gives, on the next cycle, sys_clk_en 1, resume_vld 1 and resume_act 4'b1000 (full reset); pdf and to_flag are left unchanged.
- R5: A wdt_ovf during halt (no ext_reset) sets to_flag, keeps pdf, reopens the clock and issues resume_act 4'b0100 (warm reset); a wdt_ovf while running has no effect on any output.
- R6: During halt, an interrupt flag that rises while it was clear at halt entry wakes the core; resume_act is 4'b0010 (take interrupt) when at least one such new flag has its enable bit set and stack_full is 0, and 4'b0001 (next instruction) otherwise.
- R7: An interrupt flag that was already set on the cycle halt_req was accepted cannot wake the core for the rest of that halt.
- R8: During halt, a high-to-low change on a port_in bit whose wake_mask bit is 1 wakes the core with resume_act 4'b0001; the strobe appears on the third rising edge after the change; bits with a 0 mask bit never wake.
- R9: When several wake sources are present in one cycle, the order is ext_reset, then wdt_ovf, then a new interrupt, then a port edge.
- R10: resume_vld is high for exactly one cycle per wake, on the same cycle sys_clk_en returns to 1; resume_act is one-hot while resume_vld is 1 and zero otherwise.
- R11: halt_req and clrwdt_req during halt have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running low-frequency clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_reset | input | 1 | External reset request, synchronous, active high |
| halt_req | input | 1 | Halt instruction strobe from the core |
| clrwdt_req | input | 1 | Clear-watchdog instruction strobe |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| irq_flag | input | NUM_IRQ | Interrupt request flags |
| irq_en | input | NUM_IRQ | Per-interrupt enables |
| stack_full | input | 1 | Return stack has no free entry |
| port_in | input | PORT_W | Asynchronous input port |
| wake_mask | input | PORT_W | 1 selects the port bit as a wake source |
| sys_clk_en | output | 1 | Core clock gate enable |
| pdf | output | 1 | Power-down status bit |
| to_flag | output | 1 | Watchdog time-out status bit |
| wdt_clr | output | 1 | One-cycle watchdog restart pulse |
| resume_vld | output | 1 | Resume strobe |
| resume_act | output | 4 | One-hot resume code: bit0 next, bit1 interrupt, bit2 warm, bit3 full |

## Verification
Strobes and interrupt, watchdog and reset inputs take effect one rising edge after they are applied, so the bench drives on falling edges and samples on the following falling edge. A port edge must first cross the two synchronizer stages and the previous-value register, so its strobe is due three rising edges after the change; the directed port test checks that the gate stays shut after the first and second edges and opens after the third. A behavioural model updated on every rising edge, with a queue holding the port history, is compared against every output on every falling edge through directed and random phases.

// File: rtl/hw_pkg.sv
package hw_pkg;
    typedef logic [3:0] act_t;
    localparam act_t ACT_NONE = 4'b0000;
    localparam act_t ACT_NEXT = 4'b0001;
    localparam act_t ACT_IRQ  = 4'b0010;
    localparam act_t ACT_WARM = 4'b0100;
    localparam act_t ACT_FULL = 4'b1000;
endpackage

// File: rtl/hw_edge_detect.sv
module hw_edge_detect #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] mask,
    output logic [W-1:0] fall
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] sync_q [STAGES];
    logic [W-1:0] sync_d [STAGES];
    logic [W-1:0] prev_q, prev_d;

    always_comb begin
        sync_d[0] = pin;
        for (int i = 1; i < STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
        prev_d = sync_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                sync_q[i] <= '0;
            end
            prev_q <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                sync_q[i] <= sync_d[i];
            end
            prev_q <= prev_d;
        end
    end

    assign fall = prev_q & ~sync_q[LAST] & mask;
endmodule

// File: rtl/hw_wake_arbiter.sv
module hw_wake_arbiter
    import hw_pkg::*;
#(
    parameter int NUM_IRQ = 2
) (
    input  logic               wdt_ovf,
    input  logic [NUM_IRQ-1:0] irq_new,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               stack_full,
    input  logic               port_fall,
    output logic               wake,
    output act_t               act
);
    logic irq_take;

    always_comb begin
        irq_take = ((irq_new & irq_en) != '0) && !stack_full;
        wake     = 1'b1;
        if (wdt_ovf) begin
            act = ACT_WARM;
        end else if (irq_new != '0) begin
            act = irq_take ? ACT_IRQ : ACT_NEXT;
        end else if (port_fall) begin
            act = ACT_NEXT;
        end else begin
            act  = ACT_NONE;
            wake = 1'b0;
        end
    end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import hw_pkg::*;
#(
    parameter int NUM_IRQ     = 2,
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_reset,
    input  logic               halt_req,
    input  logic               clrwdt_req,
    input  logic               wdt_ovf,
    input  logic [NUM_IRQ-1:0] irq_flag,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               stack_full,
    input  logic [PORT_W-1:0]  port_in,
    input  logic [PORT_W-1:0]  wake_mask,
    output logic               sys_clk_en,
    output logic               pdf,
    output logic               to_flag,
    output logic               wdt_clr,
    output logic               resume_vld,
    output logic [3:0]         resume_act
);
    typedef struct packed {
        logic               run;
        logic               pdf;
        logic               to;
        logic               clr;
        logic               vld;
        act_t               act;
        logic [NUM_IRQ-1:0] held;
    } ctl_t;

    ctl_t s_q, s_d;

    logic [PORT_W-1:0]  fall_vec;
    logic               fall_any;
    logic [NUM_IRQ-1:0] irq_new;
    logic               wake;
    act_t               wake_act;

    hw_edge_detect #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (port_in),
        .mask (wake_mask),
        .fall (fall_vec)
    );

    assign fall_any = |fall_vec;
    assign irq_new  = irq_flag & ~s_q.held;

    hw_wake_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .wdt_ovf   (wdt_ovf),
        .irq_new   (irq_new),
        .irq_en    (irq_en),
        .stack_full(stack_full),
        .port_fall (fall_any),
        .wake      (wake),
        .act       (wake_act)
    );

    always_comb begin
        s_d     = s_q;
        s_d.clr = 1'b0;
        s_d.vld = 1'b0;
        s_d.act = ACT_NONE;
        if (ext_reset) begin
            s_d.run = 1'b1;
            s_d.vld = 1'b1;
            s_d.act = ACT_FULL;
        end else if (s_q.run) begin
            if (halt_req) begin
                s_d.run  = 1'b0;
                s_d.pdf  = 1'b1;
                s_d.to   = 1'b0;
                s_d.clr  = 1'b1;
                s_d.held = irq_flag;
            end else if (clrwdt_req) begin
                s_d.pdf = 1'b0;
                s_d.clr = 1'b1;
            end
        end else if (wake) begin
            s_d.run = 1'b1;
            s_d.vld = 1'b1;
            s_d.act = wake_act;
            if (wake_act == ACT_WARM) begin
                s_d.to = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.run  <= 1'b1;
            s_q.pdf  <= 1'b0;
            s_q.to   <= 1'b0;
            s_q.clr  <= 1'b0;
            s_q.vld  <= 1'b0;
            s_q.act  <= ACT_NONE;
            s_q.held <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sys_clk_en = s_q.run;
    assign pdf        = s_q.pdf;
    assign to_flag    = s_q.to;
    assign wdt_clr    = s_q.clr;
    assign resume_vld = s_q.vld;
    assign resume_act = s_q.act;

    // R2
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_clk_en && halt_req && !ext_reset) |=> (!sys_clk_en && pdf && !to_flag && wdt_clr));

    // R4
    ext_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_reset |=> (sys_clk_en && resume_vld && resume_act == ACT_FULL));

    // R5
    warm_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clk_en && wdt_ovf && !ext_reset) |=> (to_flag && pdf && resume_act == ACT_WARM));

    // R7
    stay_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clk_en && !ext_reset && !wdt_ovf && irq_new == '0 && !fall_any) |=> !sys_clk_en);

    // R10
    onehot_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vld |-> ($countones(resume_act) == 1 && sys_clk_en));

    // R10
    idle_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resume_vld |-> (resume_act == ACT_NONE));

    // R10
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_vld && !ext_reset) |=> !resume_vld);
endmodule

// File: tb/tb_halt_wake_ctrl.sv
`timescale 1ns/1ps
module tb_halt_wake_ctrl;
    localparam int NI = 2;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_reset = 0, halt_req = 0, clrwdt_req = 0, wdt_ovf = 0, stack_full = 0;
    logic [NI-1:0] irq_flag = '0, irq_en = '0;
    logic [PW-1:0] port_in = '1, wake_mask = '0;
    logic sys_clk_en, pdf, to_flag, wdt_clr, resume_vld;
    logic [3:0] resume_act;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    halt_wake_ctrl #(.NUM_IRQ(NI), .PORT_W(PW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .ext_reset(ext_reset), .halt_req(halt_req),
        .clrwdt_req(clrwdt_req), .wdt_ovf(wdt_ovf), .irq_flag(irq_flag),
        .irq_en(irq_en), .stack_full(stack_full), .port_in(port_in),
        .wake_mask(wake_mask), .sys_clk_en(sys_clk_en), .pdf(pdf),
        .to_flag(to_flag), .wdt_clr(wdt_clr), .resume_vld(resume_vld),
        .resume_act(resume_act)
    );

    // behavioural reference model
    bit m_run, m_pdf, m_to, m_clr, m_vld;
    int m_act;
    logic [NI-1:0] m_pend;
    logic [PW-1:0] hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 1; m_pdf = 0; m_to = 0; m_clr = 0; m_vld = 0; m_act = 0;
            m_pend = '0;
            hist = {};
            for (int i = 0; i < 3; i++) hist.push_back('0);
        end else begin
            logic [PW-1:0] edges;
            logic [NI-1:0] fresh;
            edges = hist[2] & ~hist[1] & wake_mask;
            hist.push_front(port_in);
            void'(hist.pop_back());
            fresh = irq_flag & ~m_pend;
            m_clr = 0; m_vld = 0; m_act = 0;
            if (ext_reset) begin
                m_run = 1; m_vld = 1; m_act = 8;
            end else if (m_run) begin
                if (halt_req) begin
                    m_run = 0; m_pdf = 1; m_to = 0; m_clr = 1; m_pend = irq_flag;
                end else if (clrwdt_req) begin
                    m_pdf = 0; m_clr = 1;
                end
            end else if (wdt_ovf) begin
                m_run = 1; m_vld = 1; m_act = 4; m_to = 1;
            end else if (fresh != 0) begin
                m_run = 1; m_vld = 1;
                m_act = (((fresh & irq_en) != 0) && !stack_full) ? 2 : 1;
            end else if (edges != 0) begin
                m_run = 1; m_vld = 1; m_act = 1;
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model sys_clk_en", int'(sys_clk_en), int'(m_run));
            chk("R3 model pdf", int'(pdf), int'(m_pdf));
            chk("R5 model to_flag", int'(to_flag), int'(m_to));
            chk("R2 model wdt_clr", int'(wdt_clr), int'(m_clr));
            chk("R10 model resume_vld", int'(resume_vld), int'(m_vld));
            chk("R6 model resume_act", int'(resume_act), m_act);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_halt();
        halt_req = 1; step(); halt_req = 0;
    endtask

    initial begin
        step(3);
        chk("R1 reset sys_clk_en", int'(sys_clk_en), 1);
        chk("R1 reset pdf", int'(pdf), 0);
        chk("R1 reset resume_vld", int'(resume_vld), 0);
        chk("R1 reset resume_act", int'(resume_act), 0);
        rst_n = 1;
        step(2);

        // R2 halt entry
        do_halt();
        chk("R2 clock gated", int'(sys_clk_en), 0);
        chk("R2 pdf set", int'(pdf), 1);
        chk("R2 wdt_clr pulse", int'(wdt_clr), 1);
        step();
        chk("R2 wdt_clr ends", int'(wdt_clr), 0);
        // R11 halt and clear-watchdog ignored while halted
        halt_req = 1; clrwdt_req = 1; step(); halt_req = 0; clrwdt_req = 0;
        chk("R11 no wdt_clr in halt", int'(wdt_clr), 0);
        chk("R11 pdf kept in halt", int'(pdf), 1);
        // R6 interrupt wake, enabled, stack free
        irq_en = 2'b01; irq_flag = 2'b01; step();
        chk("R6 take interrupt", int'(resume_act), 2);
        chk("R10 clock reopens with strobe", int'(sys_clk_en), 1);
        step();
        chk("R10 strobe one cycle", int'(resume_vld), 0);
        irq_flag = 2'b00; step();

        // R7 flag pending at entry
        irq_flag = 2'b01; step();
        do_halt(); step(4);
        chk("R7 pending flag no wake", int'(sys_clk_en), 0);
        irq_flag = 2'b11; step();
        chk("R6 disabled interrupt resumes next", int'(resume_act), 1);
        irq_flag = 2'b00; step();

        // R6 stack full
        do_halt();
        irq_en = 2'b11; stack_full = 1; irq_flag = 2'b10; step();
        chk("R6 stack full resumes next", int'(resume_act), 1);
        irq_flag = 2'b00; stack_full = 0; step();

        // R8 port wake
        wake_mask = 8'h01; step(4);
        do_halt();
        port_in[1] = 0; step(5);
        chk("R8 unmasked bit ignored", int'(sys_clk_en), 0);
        port_in[0] = 0; step();
        chk("R8 edge after one edge", int'(sys_clk_en), 0);
        step();
        chk("R8 edge after two edges", int'(sys_clk_en), 0);
        step();
        chk("R8 port wake", int'(resume_act), 1);
        port_in = '1; step(4);

        // R5 watchdog in halt
        do_halt();
        wdt_ovf = 1; step(); wdt_ovf = 0;
        chk("R5 warm reset", int'(resume_act), 4);
        chk("R5 to set", int'(to_flag), 1);
        chk("R5 pdf kept", int'(pdf), 1);
        wdt_ovf = 1; step(); wdt_ovf = 0;
        chk("R5 overflow in run ignored", int'(resume_vld), 0);

        // R3 clear watchdog
        clrwdt_req = 1; step(); clrwdt_req = 0;
        chk("R3 pdf cleared", int'(pdf), 0);
        chk("R3 wdt_clr pulse", int'(wdt_clr), 1);
        chk("R3 to unchanged", int'(to_flag), 1);
        clrwdt_req = 1; halt_req = 1; step(); clrwdt_req = 0; halt_req = 0;
        chk("R3 halt wins", int'(pdf), 1);

        // R9 priority
        ext_reset = 1; wdt_ovf = 1; irq_flag = 2'b01; step(); ext_reset = 0; wdt_ovf = 0;
        chk("R9 reset first", int'(resume_act), 8);
        chk("R4 pdf unchanged", int'(pdf), 1);
        irq_flag = 2'b00; step();
        do_halt();
        wdt_ovf = 1; irq_flag = 2'b01; step(); wdt_ovf = 0;
        chk("R9 watchdog over interrupt", int'(resume_act), 4);
        irq_flag = 2'b00; step();

        // R4 external reset while running
        ext_reset = 1; step(); ext_reset = 0;
        chk("R4 full reset", int'(resume_act), 8);
        chk("R4 clock on", int'(sys_clk_en), 1);

        // random phase against the model
        for (int n = 0; n < 4000; n++) begin
            ext_reset  = ($urandom_range(0, 99) == 0);
            halt_req   = ($urandom_range(0, 7) == 0);
            clrwdt_req = ($urandom_range(0, 9) == 0);
            wdt_ovf    = ($urandom_range(0, 39) == 0);
            stack_full = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 11) == 0) irq_flag = NI'($urandom);
            if ($urandom_range(0, 31) == 0) irq_en = NI'($urandom);
            if ($urandom_range(0, 5) == 0) port_in = PW'($urandom);
            if ($urandom_range(0, 63) == 0) wake_mask = PW'($urandom);
            step();
        end
        ext_reset = 0; halt_req = 0; clrwdt_req = 0; wdt_ovf = 0;
        step(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule